// File: doc/BRIEF.md
# Multidrop-Capable Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a line that rests high. A character is offered on a byte input with a valid/ready handshake. Once it is taken, the block sends a low start bit, then the data bits with the least significant bit first, then an optional check bit, then one or two high stop bits. Each bit lasts sixteen pulses of an external one-cycle baud tick.

A 3-bit character code selects both the data width and the stop-bit count. A parity enable and a parity sense choose between no check bit, odd parity and even parity. In multidrop mode the check slot carries a fixed level instead of a computed one: space (0) or mark (1). A receiver on a shared bus uses that level to tell address characters from data characters. The shape of the frame is taken from the control inputs at the moment the character is accepted and stays fixed until the frame ends.

Top module: `mdropUartTx`

## Requirements
- R1: charCode[1:0] sets the data width: 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. The data bits are sent least significant bit first, and unused upper bits of txData are not sent.
- R2: charCode[2] = 0 gives one stop bit and charCode[2] = 1 gives two stop bits. Stop bits are high.
- R3: When parityEn = 0, no check bit is sent. The stop bits follow the last data bit directly.
- R4: When parityEn = 1, multiDrop = 0 and paritySel = 0, the check bit makes the number of ones in the sent data bits plus the check bit odd.
- R5: When parityEn = 1, multiDrop = 0 and paritySel = 1, the check bit makes that number even.
- R6: When parityEn = 1 and multiDrop = 1, the check bit is paritySel itself (0 = space, 1 = mark), whatever the data.
- R7: A frame starts with one low start bit. Every bit of the frame (start, data, check, stop) lasts exactly 16 baud ticks, and the start bit is on txOut in the cycle after acceptance.
- R8: charCode, parityEn, paritySel and multiDrop are sampled when the character is accepted. Changes to them during the frame do not affect that frame.
- R9: txReady is low and busy is high from the cycle after acceptance until the tick that ends the last stop bit. In the cycle after that tick, txReady is high and busy is low. While no frame is in progress, txOut is high.
- R10: txValid asserted while busy is high is not accepted, and txData offered then does not appear on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 8 | Character to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | Block can accept a character this cycle |
| baudTick | input | 1 | One-cycle pulse, 16 per bit time |
| charCode | input | 3 | [1:0] data width code, [2] two stop bits |
| parityEn | input | 1 | Send a check bit |
| paritySel | input | 1 | 0 = odd or space, 1 = even or mark |
| multiDrop | input | 1 | Check bit is the fixed level paritySel |
| busy | output | 1 | A frame is in progress |
| txOut | output | 1 | Serial line, idle high |

## Verification
Most internal faults show up on txOut within one bit time. A wrong bit index or shift gives a wrong data level at the middle sample of that bit. A wrong width or parity decode adds, drops or flips the bit sampled in the check slot. A tick counter off by one moves every later bit edge, and the end of the frame then misses its exact tick, so busy and txReady change a tick early or late. Configuration that is not held is caught because the bench changes every control input in the middle of each frame, and junk offered while busy would show up as an unexpected frame or a wrong byte.

// File: rtl/mdtx_pkg.sv
package mdtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    txState_t phase;
  } txStrobe_t;
endpackage

// File: rtl/mdtx_ctrl.sv
module mdtx_ctrl
  import mdtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  input  logic      baudTick,
  input  logic [2:0] charCode,
  input  logic      parityEn,
  output txStrobe_t strb,
  output logic      busy,
  output logic      txReady
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(DATA_W - 4);

  txState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             stopIdx;
  logic [2:0]       cfgCode;
  logic             cfgPar;
  logic             bitDone;
  logic [IDX_W-1:0] lastIdx;

  assign bitDone = baudTick && (tickCnt == CNT_LAST);
  assign lastIdx = IDX_BASE + IDX_W'(cfgCode[1:0]);
  assign busy    = (state != ST_IDLE);
  assign txReady = !busy;

  always_comb begin
    strb.load  = (state == ST_IDLE) && txValid;
    strb.shift = (state == ST_DATA) && bitDone;
    strb.phase = state;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
      cfgCode <= '0;
      cfgPar  <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (txValid) begin
        state   <= ST_START;
        tickCnt <= '0;
        cfgCode <= charCode;
        cfgPar  <= parityEn;
      end
    end else if (baudTick) begin
      if (tickCnt != CNT_LAST) begin
        tickCnt <= tickCnt + 1'b1;
      end else begin
        tickCnt <= '0;
        case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
          ST_DATA: begin
            if (bitIdx == lastIdx) begin
              state   <= cfgPar ? ST_PAR : ST_STOP;
              stopIdx <= 1'b0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          ST_PAR: begin
            state   <= ST_STOP;
            stopIdx <= 1'b0;
          end
          ST_STOP: begin
            if (cfgCode[2] && !stopIdx) stopIdx <= 1'b1;
            else                        state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdtx_dpath.sv
module mdtx_dpath
  import mdtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] txData,
  input  logic [1:0]        lenCode,
  input  logic              paritySel,
  input  logic              multiDrop,
  output logic              txOut
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] lenMask;
  logic              parBit;
  logic              onesOdd;
  logic              parNext;

  // Keep only the bits of the selected width when computing parity
  assign lenMask = {DATA_W{1'b1}} >> (2'd3 - lenCode);
  assign onesOdd = ^(txData & lenMask);
  assign parNext = multiDrop ? paritySel : (paritySel ? onesOdd : !onesOdd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else if (strb.load) begin
      shReg  <= txData;
      parBit <= parNext;
    end else if (strb.shift) begin
      shReg  <= shReg >> 1;
    end
  end

  always_comb begin
    case (strb.phase)
      ST_START: txOut = 1'b0;
      ST_DATA:  txOut = shReg[0];
      ST_PAR:   txOut = parBit;
      default:  txOut = 1'b1;
    endcase
  end
endmodule

// File: rtl/mdropUartTx.sv
module mdropUartTx
  import mdtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              baudTick,
  input  logic [2:0]        charCode,
  input  logic              parityEn,
  input  logic              paritySel,
  input  logic              multiDrop,
  output logic              busy,
  output logic              txOut
);
  txStrobe_t strb;

  mdtx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .txValid(txValid), .baudTick(baudTick),
    .charCode(charCode), .parityEn(parityEn), .strb(strb),
    .busy(busy), .txReady(txReady)
  );

  mdtx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData),
    .lenCode(charCode[1:0]), .paritySel(paritySel), .multiDrop(multiDrop),
    .txOut(txOut)
  );
endmodule

// File: rtl/mdtx_checker.sv
module mdtx_checker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic baudTick,
  input logic busy,
  input logic txOut
);
  // R9: line rests high outside a frame
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R7: accepted character starts with a low start bit on the next cycle
  a_r7_start_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (busy && !txOut));

  // R9: a frame can only end on a baud tick
  a_r9_end_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !baudTick) |=> busy);

  // R2: the last bit before release is a high stop bit
  a_r2_stop_before_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(txOut));
endmodule

bind mdropUartTx mdtx_checker chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .baudTick(baudTick), .busy(busy), .txOut(txOut)
);

// File: tb/mdropUartTx_tb.sv
module mdropUartTx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int TICK_DIV   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       baudTick = 1'b0;
  logic [2:0] charCode = '0;
  logic       parityEn = 1'b0;
  logic       paritySel = 1'b0;
  logic       multiDrop = 1'b0;
  logic       busy;
  logic       txOut;

  int errors = 0;
  int checks = 0;
  int divCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divCnt   <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    baudTick <= (divCnt == 0);
  end

  mdropUartTx dut_i (
    .clk(clk), .rstN(rstN), .txData(txData), .txValid(txValid),
    .txReady(txReady), .baudTick(baudTick), .charCode(charCode),
    .parityEn(parityEn), .paritySel(paritySel), .multiDrop(multiDrop),
    .busy(busy), .txOut(txOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected frame, bit 0 first on the line
  function automatic int buildFrame(input logic [7:0] d, input logic [2:0] code,
                                    input bit pen, input bit psel, input bit md,
                                    output logic [11:0] bits);
    int n = 0;
    int len = 5 + int'(code[1:0]);
    bit ones = 1'b0;
    bits = '1;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < len; i++) begin
      bits[n] = d[i]; ones ^= d[i]; n++;
    end
    if (pen) begin
      if (md) bits[n] = psel;
      else    bits[n] = psel ? ones : !ones;
      n++;
    end
    n += code[2] ? 2 : 1;
    return n;
  endfunction

  function automatic string reqOf(input int idx, input int len, input bit pen);
    if (idx == 0) return "R7";
    if (idx <= len) return "R1";
    if (pen && idx == len + 1) return "R4/R5/R6";
    return "R2";
  endfunction

  task automatic sendFrame(input logic [7:0] d, input logic [2:0] code,
                           input bit pen, input bit psel, input bit md);
    logic [11:0] bits;
    int nb;
    int ticks = 0;
    int len = 5 + int'(code[1:0]);
    bit early = 1'b0;
    nb = buildFrame(d, code, pen, psel, md, bits);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = d; charCode = code; parityEn = pen; paritySel = psel;
    multiDrop = md; txValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    check(busy && !txReady, "R9 busy after accept", int'(busy), 1);
    check(txOut == 1'b0, "R7 start bit next cycle", int'(txOut), 0);
    while (ticks < OVS * nb) begin
      @(posedge clk);
      if (baudTick) ticks++;
      @(negedge clk);
      if (ticks == 20) begin
        // R8 / R10: disturb controls and offer junk while busy
        txData = ~d; charCode = 3'($urandom); parityEn = 1'($urandom);
        paritySel = 1'($urandom); multiDrop = 1'($urandom); txValid = 1'b1;
      end
      if (ticks < OVS * nb && (!busy || txReady)) early = 1'b1;
      if (ticks == OVS * nb - OVS/2) txValid = 1'b0;
      if ((ticks % OVS) == OVS/2 && baudTick == 1'b0 && 1'b0) early = 1'b1;
    end
    check(!early, "R9 held busy whole frame", int'(early), 0);
    check(!busy && txReady && txOut, "R9 release on last tick", int'(busy), 0);
  endtask

  // Mid-bit sampler runs alongside sendFrame and compares every bit
  logic [11:0] expBits;
  int          expNb = 0;
  int          expLen = 0;
  bit          expPen = 1'b0;
  bit          sampling = 1'b0;

  task automatic runFrame(input logic [7:0] d, input logic [2:0] code,
                          input bit pen, input bit psel, input bit md);
    expNb = buildFrame(d, code, pen, psel, md, expBits);
    expLen = 5 + int'(code[1:0]);
    expPen = pen;
    fork
      sendFrame(d, code, pen, psel, md);
      begin
        int t = 0;
        @(negedge clk);
        while (!txReady) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        while (t < OVS * expNb) begin
          @(posedge clk);
          if (baudTick) begin
            t++;
            @(negedge clk);
            if ((t % OVS) == OVS/2) begin
              int idx = t / OVS;
              check(txOut == expBits[idx], reqOf(idx, expLen, expPen),
                    int'(txOut), int'(expBits[idx]));
            end
          end else begin
            @(negedge clk);
          end
        end
      end
    join
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txReady && !busy && txOut, "R9 reset state", int'(busy), 0);

    // Directed: every width and stop code, each parity flavour
    runFrame(8'hA5, 3'b000, 1'b0, 1'b0, 1'b0);  // R1 R3 5 bits, 1 stop
    runFrame(8'h3C, 3'b001, 1'b1, 1'b0, 1'b0);  // R4 odd
    runFrame(8'h3C, 3'b010, 1'b1, 1'b1, 1'b0);  // R5 even
    runFrame(8'hFF, 3'b011, 1'b1, 1'b1, 1'b0);  // R5 all ones
    runFrame(8'h00, 3'b100, 1'b1, 1'b0, 1'b0);  // R4 zero data, R2 two stop
    runFrame(8'hFF, 3'b111, 1'b1, 1'b0, 1'b1);  // R6 space with all ones
    runFrame(8'h00, 3'b110, 1'b1, 1'b1, 1'b1);  // R6 mark with zero data
    runFrame(8'hE0, 3'b101, 1'b0, 1'b1, 1'b1);  // R3 upper bits unsent

    for (int k = 0; k < 40; k++) begin
      runFrame(8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    check(txOut && txReady, "R10 no junk frame after release", int'(txOut), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule